// File: doc/BRIEF.md
# EDC Diagnostic Error Logger

This block sits next to a 32-bit error detection and correction datapath and keeps a diagnostic record of memory read errors. The syndrome generator and the correction network live elsewhere; their results arrive here as inputs. These inputs are the raw memory word, the corrected word, the syndrome, an active-low error flag and a multiple-bit error flag. Whenever a sample pulse arrives with the error flag low, the block counts the error. If the count was zero, it also stores the raw word, the syndrome and the error type, so the stored record always describes the first error since the last clear.

A 3-bit mode input selects what the 32-bit system-data output carries. In the normal and detect-only modes it carries the corrected word, and the detect-only mode also raises a correction-inhibit flag. Two further modes read back the stored first-error word or a packed diagnostic word. A checkbit-injection mode loads the checkbit latch from a system-bus value instead of from memory. Injected checkbits let the correction path be exercised on the board. After a clear, the error-data mode returns an all-zero word, which can serve as a fill pattern for memory initialization.

Top module: `edc_diag_logger`

## Requirements
- R1: On a clock edge with `smp`=1, `err_n`=0 and `clr_n`=1, the error-data register takes `mem_data` only if the error count was 0; otherwise it keeps its value.
- R2: Under the same condition, the syndrome register takes `syndrome` only if the count was 0.
- R3: The 4-bit error count rises by one on each edge with `smp`=1, `err_n`=0 and `clr_n`=1, and stays at 15 once it reaches 15.
- R4: The 2-bit error type is captured only with the first error after a clear: 2'b10 when `multi_err`=1, 2'b01 when `multi_err`=0.
- R5: `clr_n`=0 at a clock edge zeroes the error-data, syndrome, count and type registers, and it takes priority over a capture on the same edge. `clr_n` does not affect the checkbit latch.
- R6: With mode 3'b011 and `oe`=1, `sys_dout` = {type[1:0], 2'b00, count[3:0], syndrome reg[7:0], `part_chk`[7:0], `chk_q`[7:0]}, from bit 31 down to bit 0.
- R7: With mode 3'b010 and `oe`=1, `sys_dout` equals the error-data register.
- R8: On an edge with `mem_latch_stb`=1, `chk_q` loads the injection latch value when mode is 3'b100, and `mem_chk` otherwise. The injection latch loads `inj_din` on edges with `inj_le`=1.
- R9: `corr_inhibit` is 1 exactly when mode is 3'b001, and in that mode `sys_dout` carries `corr_data` when `oe`=1.
- R10: Modes 3'b000, 3'b100, 3'b101, 3'b110 and 3'b111 with `oe`=1 drive `corr_data` onto `sys_dout`.
- R11: With `oe`=0, `sys_dout` is all zeros regardless of mode.
- R12: While `rst_n` is 0 at a clock edge, all stored state, including both latches, returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n | input | 1 | Active-low clear of the error record |
| smp | input | 1 | Sample pulse marking an error-check point |
| err_n | input | 1 | Active-low error-detected flag |
| multi_err | input | 1 | Detected error spans several bits |
| mem_data | input | 32 | Uncorrected memory word |
| corr_data | input | 32 | Corrected word from the correction network |
| mem_chk | input | 8 | Checkbits read from memory |
| part_chk | input | 8 | Partial checkbits |
| syndrome | input | 8 | Syndrome bits of the current word |
| mem_latch_stb | input | 1 | Strobe that loads the checkbit latch |
| inj_din | input | 8 | Checkbit value from the system bus |
| inj_le | input | 1 | Load enable of the injection latch |
| mode | input | 3 | Operating mode select |
| oe | input | 1 | System-data output enable |
| sys_dout | output | 32 | System-data output word |
| chk_q | output | 8 | Checkbit latch contents |
| corr_inhibit | output | 1 | Correction disabled (detect-only mode) |

## Verification
The bench goes after the first-error rule: a design that captured on every error would show the syndrome and the word of the latest error instead of the first. It pushes the count past 15; a counter that wrapped would read 0 and would then store a later error again. It asserts clear and an error sample on the same edge, where a design with the wrong priority would leave a count of 1. It also covers the unused mode codes and injection with `mode` changing under the strobe, where a misdecoded mode would route the wrong word or checkbit source.

// File: rtl/edc_diag_pkg.sv
// Package: shared mode encoding for the EDC diagnostic logger.
// Assumes a 3-bit mode field; unlisted codes behave as normal mode.
package edc_diag_pkg;
    typedef enum logic [2:0] {
        MODE_NORMAL  = 3'b000,
        MODE_GEN_DET = 3'b001,
        MODE_ERR_OUT = 3'b010,
        MODE_DIAG    = 3'b011,
        MODE_CHK_INJ = 3'b100
    } edc_mode_e;

    localparam int TEST_W = 2;
endpackage

// File: rtl/edc_err_capture.sv
// Module: first-error record and saturating error counter.
// Assumes one qualified error per clock when smp=1 and err_n=0.
// Clear is synchronous and wins over a capture on the same edge.
module edc_err_capture #(
    parameter int DATA_W = 32,
    parameter int SYN_W  = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              smp,
    input  logic              err_n,
    input  logic              multi_err,
    input  logic [DATA_W-1:0] mem_data,
    input  logic [SYN_W-1:0]  syndrome,
    output logic [DATA_W-1:0] err_data,
    output logic [SYN_W-1:0]  err_syn,
    output logic [CNT_W-1:0]  err_cnt,
    output logic [1:0]        err_type
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic hit;
    logic first;
    logic wipe;

    // Qualify the error sample and detect the first error since clear.
    always_comb begin
        hit   = smp & ~err_n;
        first = hit && (err_cnt == '0);
        wipe  = ~rst_n | ~clr_n;
    end

    // Hold the uncorrected word of the first error.
    always_ff @(posedge clk) begin
        if (wipe)       err_data <= '0;
        else if (first) err_data <= mem_data;
    end

    // Hold the syndrome of the first error.
    always_ff @(posedge clk) begin
        if (wipe)       err_syn <= '0;
        else if (first) err_syn <= syndrome;
    end

    // Hold the single/multiple type of the first error.
    always_ff @(posedge clk) begin
        if (wipe)       err_type <= 2'b00;
        else if (first) err_type <= multi_err ? 2'b10 : 2'b01;
    end

    // Count errors, stopping at the all-ones value.
    always_ff @(posedge clk) begin
        if (wipe)                           err_cnt <= '0;
        else if (hit && err_cnt != CNT_MAX) err_cnt <= err_cnt + 1'b1;
    end
endmodule

// File: rtl/edc_chk_latch.sv
// Module: injection value latch and checkbit latch with source select.
// Assumes mem_latch_stb marks the edge at which checkbits are latched.
module edc_chk_latch #(
    parameter int CHK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inj_le,
    input  logic [CHK_W-1:0] inj_din,
    input  logic             mem_latch_stb,
    input  logic [CHK_W-1:0] mem_chk,
    input  logic             inject,
    output logic [CHK_W-1:0] inj_q,
    output logic [CHK_W-1:0] chk_q
);
    // Keep the last checkbit value offered by the system bus.
    always_ff @(posedge clk) begin
        if (!rst_n)      inj_q <= '0;
        else if (inj_le) inj_q <= inj_din;
    end

    // Latch checkbits from memory or, when injecting, from the bus latch.
    always_ff @(posedge clk) begin
        if (!rst_n)             chk_q <= '0;
        else if (mem_latch_stb) chk_q <= inject ? inj_q : mem_chk;
    end
endmodule

// File: rtl/edc_out_mux.sv
// Module: system-data output selection by mode, gated by output enable.
// Assumes the diagnostic fields fill DATA_W exactly.
module edc_out_mux
    import edc_diag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CHK_W  = 8,
    parameter int CNT_W  = 4
) (
    input  edc_mode_e         mode,
    input  logic              oe,
    input  logic [DATA_W-1:0] corr_data,
    input  logic [DATA_W-1:0] err_data,
    input  logic [CHK_W-1:0]  chk_q,
    input  logic [CHK_W-1:0]  part_chk,
    input  logic [CHK_W-1:0]  err_syn,
    input  logic [CNT_W-1:0]  err_cnt,
    input  logic [1:0]        err_type,
    output logic [DATA_W-1:0] sys_dout
);
    localparam int DIAG_W = 2 + TEST_W + CNT_W + 3 * CHK_W;

    logic [DIAG_W-1:0] diag_word;

    // Pack the diagnostic word; the test field reads as zero.
    always_comb begin
        diag_word = {err_type, {TEST_W{1'b0}}, err_cnt, err_syn, part_chk, chk_q};
    end

    // Choose the output source and apply the enable.
    always_comb begin
        sys_dout = '0;
        if (oe) begin
            unique case (mode)
                MODE_ERR_OUT: sys_dout = err_data;
                MODE_DIAG:    sys_dout = DATA_W'(diag_word);
                default:      sys_dout = corr_data;
            endcase
        end
    end
endmodule

// File: rtl/edc_diag_logger.sv
// Module: top of the EDC diagnostic logger.
// Records the first read error, counts errors, reads back the record
// and handles checkbit injection. Syndrome generation and correction are
// external; their results arrive as inputs.
module edc_diag_logger
    import edc_diag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CHK_W  = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              smp,
    input  logic              err_n,
    input  logic              multi_err,
    input  logic [DATA_W-1:0] mem_data,
    input  logic [DATA_W-1:0] corr_data,
    input  logic [CHK_W-1:0]  mem_chk,
    input  logic [CHK_W-1:0]  part_chk,
    input  logic [CHK_W-1:0]  syndrome,
    input  logic              mem_latch_stb,
    input  logic [CHK_W-1:0]  inj_din,
    input  logic              inj_le,
    input  logic [2:0]        mode,
    input  logic              oe,
    output logic [DATA_W-1:0] sys_dout,
    output logic [CHK_W-1:0]  chk_q,
    output logic              corr_inhibit
);
    edc_mode_e          mode_e;
    logic [DATA_W-1:0]  err_data;
    logic [CHK_W-1:0]   err_syn;
    logic [CNT_W-1:0]   err_cnt;
    logic [1:0]         err_type;
    logic [CHK_W-1:0]   inj_q;
    logic               inject;

    // Decode the mode field into its flags.
    always_comb begin
        mode_e       = edc_mode_e'(mode);
        inject       = (mode_e == MODE_CHK_INJ);
        corr_inhibit = (mode_e == MODE_GEN_DET);
    end

    edc_err_capture #(.DATA_W(DATA_W), .SYN_W(CHK_W), .CNT_W(CNT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .smp(smp), .err_n(err_n),
        .multi_err(multi_err), .mem_data(mem_data), .syndrome(syndrome),
        .err_data(err_data), .err_syn(err_syn), .err_cnt(err_cnt),
        .err_type(err_type)
    );

    edc_chk_latch #(.CHK_W(CHK_W)) u_chk (
        .clk(clk), .rst_n(rst_n), .inj_le(inj_le), .inj_din(inj_din),
        .mem_latch_stb(mem_latch_stb), .mem_chk(mem_chk), .inject(inject),
        .inj_q(inj_q), .chk_q(chk_q)
    );

    edc_out_mux #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CNT_W(CNT_W)) u_mux (
        .mode(mode_e), .oe(oe), .corr_data(corr_data), .err_data(err_data),
        .chk_q(chk_q), .part_chk(part_chk), .err_syn(err_syn),
        .err_cnt(err_cnt), .err_type(err_type), .sys_dout(sys_dout)
    );
endmodule

// File: rtl/edc_diag_logger_chk.sv
// Module: property checker for edc_diag_logger, attached by bind.
// Assumes default widths for the packed-field comparisons.
module edc_diag_logger_chk #(
    parameter int DATA_W = 32,
    parameter int CHK_W  = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_n,
    input logic              smp,
    input logic              err_n,
    input logic [2:0]        mode,
    input logic              oe,
    input logic              mem_latch_stb,
    input logic [DATA_W-1:0] sys_dout,
    input logic [CHK_W-1:0]  chk_q,
    input logic [CHK_W-1:0]  inj_q,
    input logic [DATA_W-1:0] err_data,
    input logic [CHK_W-1:0]  err_syn,
    input logic [CNT_W-1:0]  err_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R1: a later error leaves the stored word untouched
    p_first_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && smp && !err_n && err_cnt != '0) |=> $stable(err_data));

    // R2: a later error leaves the stored syndrome untouched
    p_first_syn_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && smp && !err_n && err_cnt != '0) |=> $stable(err_syn));

    // R3: counting below the limit adds one
    p_cnt_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && smp && !err_n && err_cnt != CNT_MAX) |=> err_cnt == $past(err_cnt) + 1'b1);

    // R3: no wrap at the limit
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && err_cnt == CNT_MAX) |=> err_cnt == CNT_MAX);

    // R5: clear empties the record
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (err_cnt == '0 && err_data == '0 && err_syn == '0));

    // R7: error-data mode shows the stored word
    p_err_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && mode == 3'b010) |-> sys_dout == err_data);

    // R8: injection strobe loads the bus checkbits
    p_inject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_latch_stb && mode == 3'b100) |=> chk_q == $past(inj_q));

    // R11: disabled output is all zeros
    p_oe_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> sys_dout == '0);
endmodule

bind edc_diag_logger edc_diag_logger_chk #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CNT_W(CNT_W)) u_props (.*);

// File: tb/tb_edc_diag_logger.sv
// Bench: behavioural reference model compared with the design every clock.
module tb_edc_diag_logger;
    logic        clk = 1'b0;
    logic        rst_n, clr_n, smp, err_n, multi_err;
    logic [31:0] mem_data, corr_data;
    logic [7:0]  mem_chk, part_chk, syndrome, inj_din;
    logic        mem_latch_stb, inj_le, oe;
    logic [2:0]  mode;
    logic [31:0] sys_dout;
    logic [7:0]  chk_q;
    logic        corr_inhibit;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference state
    logic [31:0] m_data;
    logic [7:0]  m_syn, m_inj, m_chk;
    int          m_cnt;
    logic [1:0]  m_typ;

    always #10 clk = ~clk;

    edc_diag_logger dut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .smp(smp), .err_n(err_n),
        .multi_err(multi_err), .mem_data(mem_data), .corr_data(corr_data),
        .mem_chk(mem_chk), .part_chk(part_chk), .syndrome(syndrome),
        .mem_latch_stb(mem_latch_stb), .inj_din(inj_din), .inj_le(inj_le),
        .mode(mode), .oe(oe), .sys_dout(sys_dout), .chk_q(chk_q),
        .corr_inhibit(corr_inhibit)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_dout();
        if (!oe) return 32'h0;
        case (mode)
            3'b010:  return m_data;
            3'b011:  return {m_typ, 2'b00, 4'(m_cnt), m_syn, part_chk, m_chk};
            default: return corr_data;
        endcase
    endfunction

    function automatic string dout_tag();
        if (!oe) return "R11";
        case (mode)
            3'b010:  return "R7";
            3'b011:  return "R6";
            3'b001:  return "R9";
            default: return "R10";
        endcase
    endfunction

    // Compare all outputs, then let one clock edge pass and advance the model.
    task automatic cycle();
        #1;
        check(dout_tag(), sys_dout, exp_dout());
        check("R8 chk_q", {24'h0, chk_q}, {24'h0, m_chk});
        check("R9 inhibit", {31'h0, corr_inhibit}, {31'h0, mode == 3'b001});
        @(posedge clk);
        if (!rst_n) begin
            m_data = 0; m_syn = 0; m_cnt = 0; m_typ = 0; m_inj = 0; m_chk = 0;
        end else begin
            if (mem_latch_stb) m_chk = (mode == 3'b100) ? m_inj : mem_chk;
            if (inj_le) m_inj = inj_din;
            if (!clr_n) begin
                m_data = 0; m_syn = 0; m_cnt = 0; m_typ = 0;
            end else if (smp && !err_n) begin
                if (m_cnt == 0) begin
                    m_data = mem_data; m_syn = syndrome;
                    m_typ = multi_err ? 2'b10 : 2'b01;
                end
                if (m_cnt != 15) m_cnt++;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle();
        clr_n = 1; smp = 0; err_n = 1; multi_err = 0; mem_latch_stb = 0;
        inj_le = 0; oe = 1; mode = 3'b000;
    endtask

    task automatic log_err(input logic [31:0] d, input logic [7:0] s, input logic m);
        idle(); smp = 1; err_n = 0; mem_data = d; syndrome = s; multi_err = m;
        cycle();
    endtask

    initial begin
        rst_n = 0; idle(); mem_data = 0; corr_data = 32'hA5A5_0F0F;
        mem_chk = 0; part_chk = 8'h3C; syndrome = 0; inj_din = 0;
        m_data = 0; m_syn = 0; m_cnt = 0; m_typ = 0; m_inj = 0; m_chk = 0;
        @(negedge clk);
        cycle(); cycle();
        rst_n = 1;
        // R12: reset state visible in diagnostic and error-data modes
        mode = 3'b011; #1; check("R12 diag after reset", sys_dout, {24'h0, 8'h3C, 8'h00} >> 8 << 8 | 32'h0000_3C00);
        mode = 3'b010; #1; check("R12 err data after reset", sys_dout, 32'h0);
        mode = 3'b000; cycle();

        // R1 R2 R4: first error kept, second ignored
        log_err(32'hDEAD_BEEF, 8'h5A, 1'b0);
        log_err(32'h1234_5678, 8'hC3, 1'b1);
        idle(); mode = 3'b010; #1; check("R1 first word kept", sys_dout, 32'hDEAD_BEEF);
        mode = 3'b011; #1;
        check("R2 first syndrome kept", {24'h0, sys_dout[23:16]}, 32'h5A);
        check("R4 single type kept", {30'h0, sys_dout[31:30]}, 32'h1);
        check("R3 count two", {28'h0, sys_dout[27:24]}, 32'h2);
        cycle();

        // R3: saturation past 15
        for (int i = 0; i < 20; i++) log_err(32'(i), 8'(i), 1'b1);
        idle(); mode = 3'b011; #1;
        check("R3 saturated count", {28'h0, sys_dout[27:24]}, 32'hF);
        check("R6 test bits zero", {30'h0, sys_dout[29:28]}, 32'h0);
        cycle();

        // R5: clear beats a simultaneous error
        idle(); clr_n = 0; smp = 1; err_n = 0; mem_data = 32'hFFFF_0000; cycle();
        idle(); mode = 3'b011; #1;
        check("R5 clear wins count", {28'h0, sys_dout[27:24]}, 32'h0);
        mode = 3'b010; #1; check("R5 all-zero word", sys_dout, 32'h0);
        cycle();
        log_err(32'h0BAD_F00D, 8'h81, 1'b1);
        idle(); mode = 3'b011; #1;
        check("R4 multi type", {30'h0, sys_dout[31:30]}, 32'h2);
        cycle();

        // R8: injection versus memory source
        idle(); inj_din = 8'h96; inj_le = 1; cycle();
        idle(); mode = 3'b100; mem_chk = 8'h11; mem_latch_stb = 1; cycle();
        idle(); #1; check("R8 injected checkbits", {24'h0, chk_q}, 32'h96);
        mem_latch_stb = 1; cycle();
        idle(); #1; check("R8 memory checkbits", {24'h0, chk_q}, 32'h11);
        cycle();

        // R9 R10 R11: mode sweep including unused codes
        for (int md = 0; md < 8; md++) begin
            idle(); mode = 3'(md); corr_data = 32'hC0DE_0000 | 32'(md); cycle();
            oe = 0; cycle();
        end

        // mixed traffic against the model
        for (int i = 0; i < 4000; i++) begin
            clr_n = ($urandom_range(0, 31) != 0);
            smp = $urandom_range(0, 1); err_n = $urandom_range(0, 1);
            multi_err = $urandom_range(0, 1);
            mem_data = $urandom; corr_data = $urandom;
            mem_chk = 8'($urandom); part_chk = 8'($urandom);
            syndrome = 8'($urandom); inj_din = 8'($urandom);
            mem_latch_stb = $urandom_range(0, 1); inj_le = $urandom_range(0, 1);
            mode = 3'($urandom_range(0, 7)); oe = ($urandom_range(0, 7) != 0);
            cycle();
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule